// File: doc/BRIEF.md
# ADC scan-and-transfer sequencer

This block keeps a bank of analog channels refreshed in memory without processor help. Once enabled, it starts a conversion on channel 0 and waits for the converter to finish. It then writes the result to memory through a request/acknowledge write port, and moves on to the next channel. After the last programmed channel's write is acknowledged, it can raise an interrupt. It then wraps to channel 0 and repeats for as long as it stays enabled.

Software controls the block through an 8-bit control register. The register holds an enable bit, an interrupt-enable bit and a channel-count field. The count names the highest channel in the pass. Each result lands as a 16-bit word in a table that starts at a base address supplied on an input. The converter itself sits outside the block and is reached through a start/done handshake that returns a 10-bit result.

Top module: `adc_scan_dma`

## Requirements
- R1: The control register resets to 8'h00. A write loads bit 7 as the enable, bit 6 as the interrupt enable and bits 3:0 as the channel count. The read value is {enable, irq_enable, 2'b00, count}.
- R2: A write with bit 7 at 0 loads the count as 0, whatever bits 3:0 carry. The enable bit reads 0 afterwards.
- R3: Bits 5:4 of the control register always read 0.
- R4: A pass converts channels 0, 1, ... up to the count N, in ascending order, one at a time.
- R5: Each channel gets one conversion: a one-cycle start pulse, then a wait for done. Exactly one memory write follows. The write request stays high with stable address and data until it is acknowledged. Conversion start and write request are never high together.
- R6: The write address is base + 2 × channel. The write data is the 10-bit result, right-justified, with bits 15:10 at 0.
- R7: With the interrupt enable at 1, the interrupt output pulses high for exactly one cycle, in the cycle after the last channel's write is acknowledged. With it at 0, the output stays low.
- R8: A count of 12 to 15 is reserved. While such a value is held, no pass is started, and no conversion beyond channel 11 is ever started.
- R9: After the last acknowledge the next pass starts at channel 0 without idle gaps. The count is sampled when a pass begins, so a new count written during a pass applies from the next pass. A write that lands in the same cycle as the last acknowledge applies from the pass after that.
- R10: If the enable is cleared while a conversion is running, the conversion finishes and its result is not written. If it is cleared while a write is pending, the write waits for its acknowledge. In both cases the block then goes idle, and the next enable restarts at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value |
| base_addr | input | 16 | Byte address of the result table |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel being converted or transferred |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 10 | Conversion result |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory write byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| irq | output | 1 | End-of-pass interrupt pulse |

## Verification
A control register write and the acknowledge of a pass's last write can fall in the same clock edge. At that edge the sequencer samples the count for the pass it is about to start while the register takes its new value. The bench provokes this from its memory responder, which drives a count-changing write in the very cycle it acknowledges the final channel. The scoreboard expects one more pass with the old count, then passes with the new count, and still exactly one interrupt per pass.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam int unsigned CTL_W  = 8;
   localparam int unsigned BIT_EN = 7;
   localparam int unsigned BIT_IE = 6;
   localparam int unsigned CNT_LIM = 4;   // count field lives in bits 3:0

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_START = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_XFER  = 2'd3
   } seq_state_t;

endpackage

// File: rtl/adc_scan_ctlreg.sv
module adc_scan_ctlreg
   import adc_scan_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [CTL_W-1:0]       wdata,
   output logic                   en,
   output logic                   ie,
   output logic [CNT_W-1:0]       cnt,
   output logic [CTL_W-1:0]       rdata
);

   generate
      if (CNT_W < 1 || CNT_W > CNT_LIM) begin : g_bad_cnt_w
         $error("adc_scan_ctlreg: CNT_W must be 1..4");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         ie  <= 1'b0;
         cnt <= '0;
      end else if (wr) begin
         en  <= wdata[BIT_EN];
         ie  <= wdata[BIT_IE];
         cnt <= wdata[BIT_EN] ? wdata[CNT_W-1:0] : '0;
      end
   end

   always_comb begin
      rdata                = '0;
      rdata[BIT_EN]        = en;
      rdata[BIT_IE]        = ie;
      rdata[CNT_W-1:0]     = cnt;
   end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned RES_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ie,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   input  logic              mem_ack,
   output logic              conv_start,
   output logic [CNT_W-1:0]  chan,
   output logic              mem_req,
   output logic [RES_W-1:0]  res_q,
   output logic              irq
);

   localparam int unsigned CMP_W = CNT_W + 1;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << CNT_W)) begin : g_bad_num_ch
         $error("adc_scan_seq: NUM_CH must fit the count field");
      end
   endgenerate

   seq_state_t         state;
   logic [CNT_W-1:0]   last_ch;
   logic               cnt_ok;
   logic               at_last;
   logic               fin;

   assign cnt_ok  = ({1'b0, cnt} < CMP_W'(NUM_CH));
   assign at_last = (chan == last_ch);
   assign fin     = (state == SQ_XFER) && mem_ack;

   assign conv_start = (state == SQ_START);
   assign mem_req    = (state == SQ_XFER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         chan    <= '0;
         last_ch <= '0;
         res_q   <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               chan <= '0;
               if (en && cnt_ok) begin
                  last_ch <= cnt;
                  state   <= SQ_START;
               end
            end
            SQ_START: begin
               state <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (conv_done) begin
                  res_q <= conv_result;
                  state <= en ? SQ_XFER : SQ_IDLE;
               end
            end
            SQ_XFER: begin
               if (mem_ack) begin
                  if (!en) begin
                     state <= SQ_IDLE;
                  end else if (at_last) begin
                     chan <= '0;
                     if (cnt_ok) begin
                        last_ch <= cnt;
                        state   <= SQ_START;
                     end else begin
                        state   <= SQ_IDLE;
                     end
                  end else begin
                     chan  <= chan + CNT_W'(1);
                     state <= SQ_START;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= fin && at_last && ie;
   end

endmodule

// File: rtl/adc_scan_addr.sv
module adc_scan_addr #(
   parameter int unsigned AW     = 16,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned RES_W  = 10,
   parameter int unsigned WORD_W = 16
) (
   input  logic [AW-1:0]     base,
   input  logic [CNT_W-1:0]  chan,
   input  logic [RES_W-1:0]  res,
   output logic [AW-1:0]     addr,
   output logic [WORD_W-1:0] wdata
);

   localparam int unsigned BYTES = WORD_W / 8;
   localparam int unsigned SH    = $clog2(BYTES);

   generate
      if (RES_W > WORD_W) begin : g_bad_res
         $error("adc_scan_addr: RES_W exceeds WORD_W");
      end
      if (WORD_W % 8 != 0 || (1 << SH) != BYTES) begin : g_bad_word
         $error("adc_scan_addr: WORD_W must be a power-of-two number of bytes");
      end
      if (AW <= CNT_W + SH) begin : g_bad_aw
         $error("adc_scan_addr: AW too narrow for the table");
      end

      if (SH == 0) begin : g_stride1
         assign addr = base + AW'(chan);
      end else begin : g_strideN
         assign addr = base + (AW'(chan) << SH);
      end

      if (RES_W < WORD_W) begin : g_pad
         assign wdata = {{(WORD_W - RES_W){1'b0}}, res};
      end else begin : g_nopad
         assign wdata = res;
      end
   endgenerate

endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma
   import adc_scan_pkg::*;
#(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned RES_W  = 10,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned AW     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [AW-1:0]     base_addr,
   output logic              conv_start,
   output logic [CNT_W-1:0]  conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   output logic              irq
);

   logic             ctl_en;
   logic             ctl_ie;
   logic [CNT_W-1:0] ctl_cnt;
   logic [RES_W-1:0] res_q;

   adc_scan_ctlreg #(.CNT_W(CNT_W)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_wdata),
      .en    (ctl_en),
      .ie    (ctl_ie),
      .cnt   (ctl_cnt),
      .rdata (cfg_rdata)
   );

   adc_scan_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .RES_W(RES_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (ctl_en),
      .ie          (ctl_ie),
      .cnt         (ctl_cnt),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .mem_ack     (mem_ack),
      .conv_start  (conv_start),
      .chan        (conv_chan),
      .mem_req     (mem_req),
      .res_q       (res_q),
      .irq         (irq)
   );

   adc_scan_addr #(.AW(AW), .CNT_W(CNT_W), .RES_W(RES_W), .WORD_W(WORD_W)) u_addr (
      .base  (base_addr),
      .chan  (conv_chan),
      .res   (res_q),
      .addr  (mem_addr),
      .wdata (mem_wdata)
   );

endmodule

// File: rtl/adc_scan_dma_chk.sv
module adc_scan_dma_chk #(
   parameter int unsigned NUM_CH = 12,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned RES_W  = 10,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned AW     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        cfg_rdata,
   input logic [AW-1:0]     base_addr,
   input logic              conv_start,
   input logic [CNT_W-1:0]  conv_chan,
   input logic              mem_req,
   input logic [AW-1:0]     mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              irq
);

   localparam int unsigned SH = $clog2(WORD_W / 8);

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[5:4] == 2'b00);                                            // R3
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[7] |-> cfg_rdata[CNT_W-1:0] == '0);                       // R2
   AST_CHAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (32'(conv_chan) < NUM_CH));                           // R8
   AST_START_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !mem_req);                                            // R5
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R5
   AST_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr == base_addr + (AW'(conv_chan) << SH));         // R6
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_wdata >> RES_W) == '0);                             // R6
   AST_IRQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);                                                       // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cfg_rdata[6]));                                        // R7

endmodule

bind adc_scan_dma adc_scan_dma_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .RES_W(RES_W), .WORD_W(WORD_W), .AW(AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rdata  (cfg_rdata),
   .base_addr  (base_addr),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack),
   .irq        (irq)
);

// File: tb/sim_adc_scan_dma.sv
`timescale 1ns/1ps
module sim_adc_scan_dma;

   localparam int NUM_CH = 12;
   localparam int CNT_W  = 4;
   localparam int RES_W  = 10;
   localparam int WORD_W = 16;
   localparam int AW     = 16;
   localparam int ADC_LAT = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              cfg_wr;
   logic [7:0]        cfg_wdata;
   logic [7:0]        cfg_rdata;
   logic [AW-1:0]     base_addr;
   logic              conv_start;
   logic [CNT_W-1:0]  conv_chan;
   logic              conv_done;
   logic [RES_W-1:0]  conv_result;
   logic              mem_req;
   logic [AW-1:0]     mem_addr;
   logic [WORD_W-1:0] mem_wdata;
   logic              mem_ack;
   logic              irq;

   logic       drv_wr = 1'b0, mon_wr = 1'b0;
   logic [7:0] drv_wdata = '0, mon_wdata = '0;
   assign cfg_wr    = drv_wr | mon_wr;
   assign cfg_wdata = mon_wr ? mon_wdata : drv_wdata;

   adc_scan_dma u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .base_addr(base_addr), .conv_start(conv_start),
      .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .irq(irq)
   );

   typedef struct {
      logic [AW-1:0]     addr;
      logic [WORD_W-1:0] data;
      bit                trig;
   } exp_t;

   exp_t       expq[$];
   int         conv_log[$];
   int         n_chk = 0, n_bad = 0;
   int         irq_cnt = 0;
   int         ack_delay = 0;
   logic [9:0] seed = 10'h05A;
   logic [7:0] trig_val = 8'h00;

   function automatic logic [9:0] res_of(int c);
      return 10'(int'(seed) + c * 53);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push_pass(int last, bit trig_last);
      for (int c = 0; c <= last; c++) begin
         exp_t e;
         e.addr = base_addr + AW'(2 * c);
         e.data = {6'b0, res_of(c)};
         e.trig = trig_last && (c == last);
         expq.push_back(e);
      end
   endtask

   task automatic wr(logic [7:0] v);
      @(negedge clk);
      drv_wr = 1'b1; drv_wdata = v;
      @(negedge clk);
      drv_wr = 1'b0;
   endtask

   task automatic wait_empty();
      while (expq.size() != 0) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // converter model
   initial begin
      conv_done = 1'b0; conv_result = '0;
      forever begin
         @(negedge clk);
         if (conv_start) begin
            automatic int c = int'(conv_chan);
            conv_log.push_back(c);
            check(c < NUM_CH, "R8", "conversion channel in range", c, NUM_CH - 1);
            repeat (ADC_LAT - 1) @(negedge clk);
            conv_result = res_of(c);
            conv_done   = 1'b1;
            @(negedge clk);
            conv_done   = 1'b0;
         end
      end
   end

   // memory responder and scoreboard monitor
   initial begin
      mem_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_req) begin
            repeat (ack_delay) @(negedge clk);
            if (expq.size() == 0) begin
               check(1'b0, "R5", "unexpected memory write", int'(mem_addr), 0);
            end else begin
               automatic exp_t e = expq.pop_front();
               check(mem_addr == e.addr, "R6", "write address", int'(mem_addr), int'(e.addr));
               check(mem_wdata == e.data, "R6", "write data", int'(mem_wdata), int'(e.data));
               if (e.trig) begin
                  mon_wr = 1'b1; mon_wdata = trig_val;
               end
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            mon_wr  = 1'b0;
         end
      end
   end

   always @(negedge clk) if (irq) irq_cnt++;

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "R4", "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      int snap, isnap;
      rst_n = 1'b0;
      base_addr = 16'h4000;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cfg_rdata == 8'h00, "R1", "reset value", cfg_rdata, 8'h00);
      check(!irq && !mem_req && !conv_start, "R1", "outputs idle after reset", {irq, mem_req, conv_start}, 0);

      // R2, R3: disabled write clears count, reserved bits read 0
      wr(8'h73);
      check(cfg_rdata == 8'h40, "R2", "count forced 0 when disabled", cfg_rdata, 8'h40);
      check(cfg_rdata[5:4] == 2'b00, "R3", "reserved bits", cfg_rdata[5:4], 0);

      // R4, R7, R9: pass over 0..3 with interrupt, then wrap
      push_pass(3, 0);
      isnap = irq_cnt;
      wr(8'hF3);
      check(cfg_rdata == 8'hC3, "R1", "enabled readback", cfg_rdata, 8'hC3);
      while (irq_cnt == isnap) @(negedge clk);
      wr(8'h40);
      repeat (30) @(negedge clk);
      check(expq.size() == 0, "R4", "all pass writes seen", expq.size(), 0);
      check(irq_cnt == isnap + 1, "R7", "one irq per pass", irq_cnt - isnap, 1);
      check(conv_log.size() == 5, "R9", "conversions incl wrap", conv_log.size(), 5);
      check(conv_log[4] == 0, "R9", "wrap restarts at channel 0", conv_log[4], 0);
      check(cfg_rdata == 8'h40, "R2", "disable readback", cfg_rdata, 8'h40);

      // R7: interrupt enable off, single channel pass
      seed = 10'h3F1; base_addr = 16'h1230;
      isnap = irq_cnt;
      push_pass(0, 0);
      wr(8'h80);
      wait_empty();
      wr(8'h00);
      repeat (30) @(negedge clk);
      check(irq_cnt == isnap, "R7", "no irq with enable off", irq_cnt - isnap, 0);
      check(!mem_req, "R10", "idle after disable", mem_req, 0);

      // R9: count change mid-pass applies next pass
      seed = 10'h111; base_addr = 16'h4000;
      isnap = irq_cnt;
      push_pass(2, 0);
      push_pass(5, 0);
      wr(8'hC2);
      while (expq.size() > 8) @(negedge clk);
      wr(8'hC5);
      wait_empty();
      wr(8'h00);
      repeat (30) @(negedge clk);
      check(irq_cnt == isnap + 2, "R9", "irq count two passes", irq_cnt - isnap, 2);

      // R9: write coinciding with the last acknowledge
      seed = 10'h2C7;
      isnap = irq_cnt;
      trig_val = 8'hC2;
      push_pass(1, 1);
      push_pass(1, 0);
      push_pass(2, 0);
      wr(8'hC1);
      wait_empty();
      check(cfg_rdata == 8'hC2, "R1", "coincident write landed", cfg_rdata, 8'hC2);
      wr(8'h00);
      repeat (30) @(negedge clk);
      check(irq_cnt == isnap + 3, "R7", "irq per pass at coincidence", irq_cnt - isnap, 3);

      // R8: reserved count starts nothing
      snap = conv_log.size();
      wr(8'hCC);
      check(cfg_rdata == 8'hCC, "R1", "reserved count readback", cfg_rdata, 8'hCC);
      repeat (40) @(negedge clk);
      check(conv_log.size() == snap, "R8", "no conversions on reserved count", conv_log.size() - snap, 0);
      check(!mem_req, "R8", "no write on reserved count", mem_req, 0);
      wr(8'h00);

      // R10: disable with a write pending
      seed = 10'h0F0;
      snap = conv_log.size();
      ack_delay = 20;
      push_pass(0, 0);
      wr(8'h83);
      while (!mem_req) @(negedge clk);
      wr(8'h00);
      repeat (60) @(negedge clk);
      check(expq.size() == 0, "R10", "pending write completed", expq.size(), 0);
      check(conv_log.size() == snap + 1, "R10", "no conversion after disable", conv_log.size() - snap, 1);
      check(!mem_req, "R10", "idle after pending write", mem_req, 0);
      ack_delay = 0;

      // R10: disable mid-conversion, no write, restart at channel 0
      snap = conv_log.size();
      wr(8'h83);
      while (conv_log.size() == snap) @(negedge clk);
      wr(8'h00);
      repeat (30) @(negedge clk);
      check(expq.size() == 0 && !mem_req, "R10", "no write after mid-conversion disable", mem_req, 0);
      seed = 10'h1AB;
      snap = conv_log.size();
      push_pass(1, 0);
      wr(8'h81);
      wait_empty();
      wr(8'h00);
      repeat (30) @(negedge clk);
      check(conv_log[snap] == 0, "R10", "restart at channel 0", conv_log[snap], 0);
      check(conv_log[snap + 1] == 1, "R4", "ascending channel", conv_log[snap + 1], 1);

      finish_up();
   end

endmodule